// File: doc/BRIEF.md
# Packed Decimal Add/Subtract Unit

This unit adds or subtracts two signed packed-decimal numbers. It also has a copy mode that moves the second number into a field of the first number's length and pads the top with zeros. Each operand is held in a register of up to `MAX_BYTES` bytes and has its own byte length. The result is written back at the first operand's length. The unit then reports a two-bit condition code, an overflow flag and a data-exception flag.

The unit works serially. It processes one decimal digit per clock, starting at the least significant digit. Before the digit pass, a setup cycle does three things: it validates both operands, compares their magnitudes, and places the larger magnitude on the minuend side. This means that when the effective signs differ, the digit pass never has to recomplement its result.

Commands enter on a valid/ready pair. Results leave on a valid/ready pair. The unit holds one command at a time. It keeps `cmd_ready` low from the moment a command is accepted until the result has been taken. While `res_valid` is high and `res_ready` is low, the result stays frozen.

Top module: `pd_addsub_unit`

## Requirements
- R1: An operand field is right-aligned in its port. Bits [3:0] hold the sign nibble. Digit k (k = 0 is least significant) sits in bits [4k+7:4k+4]. A length code c means c+1 bytes, which is 2c+1 digits. Nibbles above the operand's length are ignored.
- R2: Op code 0 (add) returns operand 1 plus operand 2 at the first operand's length. All result bits above that length are zero.
- R3: Op code 1 (subtract) returns operand 1 minus operand 2 at the first operand's length.
- R4: Sign nibbles A, C, E and F read as positive, and B and D read as negative. A negative result carries the sign D and a positive result carries the sign C.
- R5: When there is no overflow, `res_cc` is 0 for a zero result, 1 for a negative result and 2 for a positive result.
- R6: If a nonzero digit does not fit in the first operand's length, then `res_cc` is 3 and `res_ovf` is 1. The low-order digits that do fit are still returned.
- R7: A result of zero always carries the sign C, even when the operands would give minus zero.
- R8: Op code 2 (copy) returns operand 2, zero-padded to the first operand's length. Its condition code follows R5, and R6 applies to it as well. Operand 1 is neither used nor validated in this mode.
- R9: Either of the following raises `res_dexc`, with `res_data` equal to the unmodified operand 1, `res_cc` = 0 and `res_ovf` = 0:
  - a digit nibble above 9 within an operand's length;
  - a sign nibble below A.
- R10: `cmd_ready` is high only when the unit is idle with no result pending. `busy` is high from the cycle after acceptance until `res_valid` rises.
- R11: With N = 2·max(c1,c2)+1 digits, `res_valid` rises N+2 clock edges after the accepting edge. When a data exception occurs, it rises 2 edges after that edge.
- R12: While `res_valid` is high and `res_ready` is low, the result outputs hold steady and no new command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Unit can take a command |
| cmd_op | input | 2 | 0 add, 1 subtract, 2 copy (3 acts as add) |
| cmd_len1 | input | $clog2(MAX_BYTES) | Operand 1 length code (bytes minus one) |
| cmd_len2 | input | $clog2(MAX_BYTES) | Operand 2 length code (bytes minus one) |
| cmd_opnd1 | input | 8*MAX_BYTES | Operand 1 field |
| cmd_opnd2 | input | 8*MAX_BYTES | Operand 2 field |
| busy | output | 1 | Setup or digit pass in progress |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer takes the result |
| res_data | output | 8*MAX_BYTES | Result field at operand 1 length |
| res_cc | output | 2 | Condition code |
| res_ovf | output | 1 | Decimal overflow |
| res_dexc | output | 1 | Data exception |

## Verification
The result latency depends only on the two length codes:
- A valid command produces its result 2·max(c1,c2)+3 edges after the accepting edge.
- A command that raises a data exception produces its result 2 edges after that edge.

The bench records the cycle count at each acceptance. The monitor samples on the falling edge, detects the first cycle in which `res_valid` is high, and compares the elapsed cycles with the figure that the model queued for that command. Data, condition code and flags are compared only on the cycle where `res_valid` and `res_ready` are both high. One test holds `res_ready` low for several cycles and confirms that the result stays frozen while the command port stays closed.

// File: rtl/pd_pkg.sv
package pd_pkg;
  typedef enum logic [1:0] {
    PD_ADD = 2'd0,
    PD_SUB = 2'd1,
    PD_ZAP = 2'd2,
    PD_RSV = 2'd3
  } pd_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_RUN,
    ST_FIN,
    ST_HOLD
  } pd_state_e;

  localparam logic [3:0] SIGN_POS = 4'hC;
  localparam logic [3:0] SIGN_NEG = 4'hD;

  function automatic logic sign_is_neg(input logic [3:0] s);
    return (s == 4'hB) || (s == 4'hD);
  endfunction
endpackage

// File: rtl/pd_operand_check.sv
// Validates one packed-decimal field and extracts its digit magnitude.
module pd_operand_check
  import pd_pkg::*;
#(
  parameter int MAX_BYTES = 16
) (
  input  logic [8*MAX_BYTES-1:0]       field,
  input  logic [$clog2(MAX_BYTES)-1:0] len_code,
  output logic                         bad,
  output logic                         neg,
  output logic [4*(2*MAX_BYTES-1)-1:0] mag
);
  localparam int ND = 2*MAX_BYTES-1;

  always_comb begin
    bad = (field[3:0] < 4'hA);
    neg = sign_is_neg(field[3:0]);
    mag = '0;
    for (int k = 0; k < ND; k++) begin
      if (k < 2*int'(len_code)+1) begin
        mag[4*k +: 4] = field[4*k+4 +: 4];
        if (field[4*k+4 +: 4] > 4'd9) bad = 1'b1;
      end
    end
  end
endmodule

// File: rtl/pd_digit_alu.sv
// One BCD digit of add (with carry) or subtract (with borrow).
module pd_digit_alu (
  input  logic [3:0] a,
  input  logic [3:0] b,
  input  logic       cin,
  input  logic       sub,
  output logic [3:0] d,
  output logic       cout
);
  logic [4:0] t;

  always_comb begin
    if (sub) begin
      t    = {1'b0, a} - {1'b0, b} - {4'b0, cin};
      cout = t[4];
      d    = t[4] ? (t[3:0] + 4'd10) : t[3:0];
    end else begin
      t    = {1'b0, a} + {1'b0, b} + {4'b0, cin};
      cout = (t > 5'd9);
      d    = cout ? 4'(t - 5'd10) : t[3:0];
    end
  end
endmodule

// File: rtl/pd_addsub_unit.sv
module pd_addsub_unit
  import pd_pkg::*;
#(
  parameter int MAX_BYTES = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cmd_valid,
  output logic                         cmd_ready,
  input  logic [1:0]                   cmd_op,
  input  logic [$clog2(MAX_BYTES)-1:0] cmd_len1,
  input  logic [$clog2(MAX_BYTES)-1:0] cmd_len2,
  input  logic [8*MAX_BYTES-1:0]       cmd_opnd1,
  input  logic [8*MAX_BYTES-1:0]       cmd_opnd2,
  output logic                         busy,
  output logic                         res_valid,
  input  logic                         res_ready,
  output logic [8*MAX_BYTES-1:0]       res_data,
  output logic [1:0]                   res_cc,
  output logic                         res_ovf,
  output logic                         res_dexc
);
  localparam int LW = $clog2(MAX_BYTES);
  localparam int ND = 2*MAX_BYTES-1;
  localparam int DW = 4*ND;
  localparam int W  = 8*MAX_BYTES;
  localparam int CW = $clog2(ND+1);

  pd_state_e state;
  pd_op_e    op_q;
  logic [1:0][LW-1:0] len_q;
  logic [1:0][W-1:0]  fld_q;
  logic [DW-1:0] big_q, small_q, acc_q;
  logic          eff_sub_q, neg_q, carry_q, lost_q, nz_q, dexc_q;
  logic [CW-1:0] idx_q, nd_q, nd1_q;

  // Per-operand validation and magnitude extraction
  logic [1:0]         bad_w, neg_w;
  logic [1:0][DW-1:0] mag_w;

  for (genvar g = 0; g < 2; g++) begin : g_chk
    pd_operand_check #(.MAX_BYTES(MAX_BYTES)) u_chk (
      .field    (fld_q[g]),
      .len_code (len_q[g]),
      .bad      (bad_w[g]),
      .neg      (neg_w[g]),
      .mag      (mag_w[g])
    );
  end

  // Setup decisions
  logic          is_zap, sa, sb, swap, bad_any;
  logic [DW-1:0] ma, mb;
  logic [LW-1:0] lmax;

  always_comb begin
    is_zap  = (op_q == PD_ZAP);
    sb      = neg_w[1] ^ (op_q == PD_SUB);
    sa      = is_zap ? sb : neg_w[0];
    ma      = is_zap ? '0 : mag_w[0];
    mb      = mag_w[1];
    swap    = (sa != sb) && (mb > ma);
    bad_any = bad_w[1] | (~is_zap & bad_w[0]);
    lmax    = (len_q[0] > len_q[1]) ? len_q[0] : len_q[1];
  end

  // Digit datapath
  logic [3:0] dig;
  logic       dig_c;

  pd_digit_alu u_alu (
    .a    (big_q[3:0]),
    .b    (small_q[3:0]),
    .cin  (carry_q),
    .sub  (eff_sub_q),
    .d    (dig),
    .cout (dig_c)
  );

  // Finish-time flags
  logic       fin_carry, fin_nz, fin_ovf;
  logic [1:0] fin_cc;

  always_comb begin
    fin_carry = carry_q & ~eff_sub_q;
    fin_nz    = nz_q | fin_carry;
    fin_ovf   = lost_q | fin_carry;
    if (fin_ovf)      fin_cc = 2'd3;
    else if (!fin_nz) fin_cc = 2'd0;
    else if (neg_q)   fin_cc = 2'd1;
    else              fin_cc = 2'd2;
  end

  assign cmd_ready = (state == ST_IDLE);
  assign busy      = (state == ST_SETUP) || (state == ST_RUN) || (state == ST_FIN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      op_q      <= PD_ADD;
      len_q     <= '0;
      fld_q     <= '0;
      big_q     <= '0;
      small_q   <= '0;
      acc_q     <= '0;
      eff_sub_q <= 1'b0;
      neg_q     <= 1'b0;
      carry_q   <= 1'b0;
      lost_q    <= 1'b0;
      nz_q      <= 1'b0;
      dexc_q    <= 1'b0;
      idx_q     <= '0;
      nd_q      <= '0;
      nd1_q     <= '0;
      res_valid <= 1'b0;
      res_data  <= '0;
      res_cc    <= 2'd0;
      res_ovf   <= 1'b0;
      res_dexc  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (cmd_valid) begin
          op_q     <= pd_op_e'(cmd_op);
          len_q[0] <= cmd_len1;
          len_q[1] <= cmd_len2;
          fld_q[0] <= cmd_opnd1;
          fld_q[1] <= cmd_opnd2;
          state    <= ST_SETUP;
        end
        ST_SETUP: begin
          dexc_q <= bad_any;
          if (bad_any) begin
            state <= ST_FIN;
          end else begin
            big_q     <= swap ? mb : ma;
            small_q   <= swap ? ma : mb;
            neg_q     <= swap ? sb : sa;
            eff_sub_q <= (sa != sb);
            carry_q   <= 1'b0;
            lost_q    <= 1'b0;
            nz_q      <= 1'b0;
            acc_q     <= '0;
            idx_q     <= '0;
            nd_q      <= CW'(2*int'(lmax)+1);
            nd1_q     <= CW'(2*int'(len_q[0])+1);
            state     <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (idx_q < nd1_q)        acc_q[4*idx_q +: 4] <= dig;
          else if (dig != 4'd0)     lost_q <= 1'b1;
          if (dig != 4'd0)          nz_q <= 1'b1;
          carry_q <= dig_c;
          big_q   <= big_q >> 4;
          small_q <= small_q >> 4;
          idx_q   <= idx_q + CW'(1);
          if (idx_q + CW'(1) == nd_q) state <= ST_FIN;
        end
        ST_FIN: begin
          res_valid <= 1'b1;
          state     <= ST_HOLD;
          if (dexc_q) begin
            res_data <= fld_q[0];
            res_cc   <= 2'd0;
            res_ovf  <= 1'b0;
            res_dexc <= 1'b1;
          end else begin
            res_data <= {acc_q, (fin_nz && neg_q) ? SIGN_NEG : SIGN_POS};
            res_cc   <= fin_cc;
            res_ovf  <= fin_ovf;
            res_dexc <= 1'b0;
          end
        end
        ST_HOLD: if (res_ready) begin
          res_valid <= 1'b0;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pd_addsub_unit_chk.sv
module pd_addsub_unit_chk #(
  parameter int MAX_BYTES = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cmd_valid,
  input logic                   cmd_ready,
  input logic                   busy,
  input logic                   res_valid,
  input logic                   res_ready,
  input logic [8*MAX_BYTES-1:0] res_data,
  input logic [1:0]             res_cc,
  input logic                   res_ovf,
  input logic                   res_dexc
);
  // R10: a pending result closes the command port
  p_closed_r10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !cmd_ready);

  // R10: acceptance starts busy
  p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> busy);

  // R12: stalled result holds
  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data) && $stable(res_cc)
                                   && $stable(res_ovf) && $stable(res_dexc)));

  // R6: overflow pairs with code 3
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_dexc) |-> (res_ovf == (res_cc == 2'd3)));

  // R9: exception reports code 0 and no overflow
  p_dexc_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_dexc) |-> (!res_ovf && res_cc == 2'd0));

  // R7: zero result is positive
  p_zero_sign_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_dexc && res_cc == 2'd0) |-> (res_data[3:0] == 4'hC));

  // R4: negative code carries D
  p_neg_sign_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_dexc && res_cc == 2'd1) |-> (res_data[3:0] == 4'hD));
endmodule

bind pd_addsub_unit pd_addsub_unit_chk #(.MAX_BYTES(MAX_BYTES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .busy      (busy),
  .res_valid (res_valid),
  .res_ready (res_ready),
  .res_data  (res_data),
  .res_cc    (res_cc),
  .res_ovf   (res_ovf),
  .res_dexc  (res_dexc)
);

// File: tb/pd_addsub_unit_tb.sv
module pd_addsub_unit_tb;
  localparam int MB = 16;
  localparam int W  = 8*MB;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [1:0] cmd_op = 2'd0;
  logic [3:0] cmd_len1 = '0, cmd_len2 = '0;
  logic [W-1:0] cmd_opnd1 = '0, cmd_opnd2 = '0;
  logic busy, res_valid, res_ovf, res_dexc;
  logic res_ready = 1'b1;
  logic [W-1:0] res_data;
  logic [1:0] res_cc;

  always #2 clk = ~clk;

  pd_addsub_unit #(.MAX_BYTES(MB)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_len1(cmd_len1), .cmd_len2(cmd_len2),
    .cmd_opnd1(cmd_opnd1), .cmd_opnd2(cmd_opnd2), .busy(busy),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
    .res_cc(res_cc), .res_ovf(res_ovf), .res_dexc(res_dexc));

  typedef struct {
    logic [W-1:0] data;
    logic [1:0]   cc;
    logic         ovf;
    logic         dexc;
    int           lat;
    string        req;
  } exp_t;

  exp_t exp_q[$];
  int   acc_q[$];
  int   cyc = 0;
  int   errors = 0;
  int   checks = 0;
  bit   done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  function automatic logic signed [135:0] sval(input logic [W-1:0] f, input int lc);
    logic signed [135:0] m = 0;
    for (int k = 2*lc; k >= 0; k--) m = m*10 + 136'(f[4*k+4 +: 4]);
    return (f[3:0] == 4'hB || f[3:0] == 4'hD) ? -m : m;
  endfunction

  function automatic bit is_bad(input logic [W-1:0] f, input int lc);
    bit b = (f[3:0] < 4'hA);
    for (int k = 0; k <= 2*lc; k++) if (f[4*k+4 +: 4] > 4'd9) b = 1;
    return b;
  endfunction

  function automatic exp_t model(input string req, input logic [1:0] op, input int l1,
                                 input logic [W-1:0] a, input int l2, input logic [W-1:0] b);
    exp_t e;
    logic signed [135:0] r;
    logic [135:0] m, lim, tr;
    bit neg;
    e.req  = req;
    e.data = '0;
    if (is_bad(b, l2) || (op != 2'd2 && is_bad(a, l1))) begin
      e.data = a; e.cc = 2'd0; e.ovf = 0; e.dexc = 1; e.lat = 2;
      return e;
    end
    r = (op == 2'd2) ? sval(b, l2) :
        (op == 2'd1) ? sval(a, l1) - sval(b, l2) : sval(a, l1) + sval(b, l2);
    neg = (r < 0);
    m   = neg ? 136'(-r) : 136'(r);
    lim = 1;
    for (int k = 0; k <= 2*l1; k++) lim = lim * 10;
    e.ovf  = (m >= lim);
    e.dexc = 0;
    tr = m % lim;
    e.data[3:0] = (m != 0 && neg) ? 4'hD : 4'hC;
    for (int k = 0; k <= 2*l1; k++) begin
      e.data[4*k+4 +: 4] = 4'(tr % 10);
      tr = tr / 10;
    end
    e.cc  = e.ovf ? 2'd3 : (m == 0) ? 2'd0 : neg ? 2'd1 : 2'd2;
    e.lat = 2*((l1 > l2) ? l1 : l2) + 1 + 2;
    return e;
  endfunction

  // Driver: queue the expectation, then offer the command
  task automatic send(input string req, input logic [1:0] op, input int l1,
                      input logic [W-1:0] a, input int l2, input logic [W-1:0] b);
    exp_q.push_back(model(req, op, l1, a, l2, b));
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_len1 = 4'(l1); cmd_len2 = 4'(l2);
    cmd_opnd1 = a; cmd_opnd2 = b;
    @(negedge clk);
    acc_q.push_back(cyc);
    cmd_valid = 1'b0;
  endtask

  // Monitor: latency on rise (R11), contents on handshake
  bit prev_v = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (res_valid && !prev_v) begin
        if (exp_q.size() == 0 || acc_q.size() == 0)
          chk(0, "R11", "unexpected result", W'(1), W'(0));
        else
          chk(cyc - acc_q[0] == exp_q[0].lat, "R11", "latency",
              W'(cyc - acc_q[0]), W'(exp_q[0].lat));
      end
      if (res_valid && res_ready && exp_q.size() != 0) begin
        exp_t e;
        e = exp_q.pop_front();
        void'(acc_q.pop_front());
        chk(res_data == e.data, e.req, "data", res_data, e.data);
        chk(res_cc == e.cc, e.req, "cc", W'(res_cc), W'(e.cc));
        chk(res_ovf == e.ovf, e.req, "ovf", W'(res_ovf), W'(e.ovf));
        chk(res_dexc == e.dexc, e.req, "dexc", W'(res_dexc), W'(e.dexc));
      end
      prev_v = res_valid;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] cap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    chk(cmd_ready == 1'b1, "R10", "ready after reset", W'(cmd_ready), W'(1));
    chk(res_valid == 1'b0, "R10", "valid after reset", W'(res_valid), W'(0));
    chk(busy == 1'b0, "R10", "busy after reset", W'(busy), W'(0));

    // R12: stall the first result
    res_ready = 1'b0;
    send("R2", 2'd0, 2, 128'h00805C, 1, 128'h199C);
    chk(busy == 1'b1, "R10", "busy after accept", W'(busy), W'(1));
    while (!res_valid) @(negedge clk);
    cap = res_data;
    repeat (4) @(negedge clk);
    chk(res_valid == 1'b1, "R12", "valid held", W'(res_valid), W'(1));
    chk(res_data == cap, "R12", "data held", res_data, cap);
    chk(cmd_ready == 1'b0, "R12", "port closed", W'(cmd_ready), W'(0));
    res_ready = 1'b1;

    send("R4", 2'd0, 2, 128'h00140D, 1, 128'h010C);    // R5 negative
    send("R6", 2'd0, 2, 128'h84321C, 2, 128'h42111C);  // overflow, truncated kept
    send("R3", 2'd1, 2, 128'h00805C, 1, 128'h199C);
    send("R3", 2'd1, 1, 128'h020C, 1, 128'h150C);      // larger subtrahend
    send("R3", 2'd1, 1, 128'h050C, 1, 128'h070D);
    send("R7", 2'd1, 2, 128'h12345D, 2, 128'h12345D);
    send("R7", 2'd0, 0, 128'h5D, 0, 128'h5C);          // minus zero
    send("R8", 2'd2, 3, 128'hF0F0F0F0, 2, 128'h12345C);
    send("R8", 2'd2, 0, 128'h0, 1, 128'h123C);         // copy overflow
    send("R7", 2'd2, 1, 128'h0, 1, 128'h000D);
    send("R4", 2'd0, 1, 128'h012F, 0, 128'h3C);        // F positive
    send("R4", 2'd1, 0, 128'h1D, 0, 128'h2D);
    send("R9", 2'd0, 1, 128'h1A3C, 0, 128'h1C);        // bad digit
    send("R9", 2'd0, 1, 128'h012C, 1, 128'h0015);      // bad sign
    send("R2", 2'd0, 0, 128'h5C, 2, 128'h00004C);      // longer operand 2
    send("R6", 2'd0, 15, 128'h9999_9999_9999_9999_9999_9999_9999_999C, 0, 128'h1C);
    send("R1", 2'd0, 1, 128'hABCD_012C, 1, 128'hEEEE_020C);

    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule